// File: doc/BRIEF.md
# Unlock-Sequence Command Sequencer

This block watches a synchronous command bus. Each strobed bus cycle carries a row field, a column field and a data word. The block looks for multi-cycle unlock sequences, and a fixed prefix of address/data triplets guards every command. The byte in the closing cycle picks the function. Recognised sequences start a word program or a sector erase, enable the boot-area lockout, enter continuity test, or switch the lockout-verify status view on or off.

A program or erase makes the block busy for a parameterised number of cycles, standing in for the real cell operation. While the block is busy, command cycles are dropped. A separate read port returns a polling byte one cycle after each read request:

- During a program it returns the inverted top bit of the loaded byte.
- During an erase it returns zero.
- After either operation ends it returns the final value.
- In lockout-verify mode it returns a two-bit lockout status.

The sequencer has nine states:

- `ST_IDLE`
- `ST_UNLK1` and `ST_UNLK2`: first and second prefix triplets accepted.
- `ST_PGM_ARM`: program armed, waiting for the target cycle.
- `ST_EXT1` and `ST_EXT2`: extended prefix, third and fourth triplets accepted.
- `ST_ERS_ARM`: erase armed, waiting for the sector cycle.
- `ST_PROG_BUSY` and `ST_ERASE_BUSY`

The transitions are as follows:

- **Start:** `ST_IDLE` goes to `ST_UNLK1` on the first triplet.
- **Prefix:** `ST_UNLK1` goes to `ST_UNLK2` on the second triplet.
- **Split:** `ST_UNLK2` goes to `ST_PGM_ARM` on data A0, or to `ST_EXT1` on data 80.
- **Extend:** `ST_EXT1` goes to `ST_EXT2` on data AA.
- **Five-cycle or erase arm:** from `ST_EXT2`, a closing byte of 70, 40, 90 or F0 fires its function and returns to `ST_IDLE`. The triplet (055, 2A, 55) moves to `ST_ERS_ARM` instead.
- **Launch:** `ST_PGM_ARM` and `ST_ERS_ARM` go to their busy state, or back to `ST_IDLE` when the request is refused.
- **Finish:** each busy state returns to `ST_IDLE` when its timer reaches zero.
- **Mismatch:** any sequence state falls back to `ST_UNLK1` if the wrong cycle is itself a valid first triplet, and otherwise to `ST_IDLE`.

Top module: `unlock_cmd_seq`

## Requirements
- R1: After reset the block is idle, `busy`, `op_valid` and `poll_valid` are low, lockout and verify mode are off, and a read returns FF.
- R2: The triplets (row 0x0AA, col 0x55, data AA), (0x055, 0x2A, 55) and (0x0AA, 0x55, A0) followed by a target cycle give a one-cycle `op_valid` with `op_code` 1 and `op_sector` = target row[12:10] on the cycle after the target cycle. `busy` rises on the same edge.
- R3: The prefix, then (0x0AA, 0x55, 80), (0x0AA, 0x55, AA), (0x055, 0x2A, 55), then a cycle with data 30 give `op_code` 2 with `op_sector` = that cycle's row[12:10].
- R4: The prefix, then (0x0AA, 0x55, 80) and (0x0AA, 0x55, AA), then (0x0AA, 0x55, X) give the following `op_code` values. X = 70 gives 3 (continuity test). X = 40 gives 4 and enables lockout. X = 90 gives 5 and enters verify mode. X = F0 gives 6 and leaves verify mode.
- R5: Only `cyc_data[7:0]` is compared; the upper data bits do not affect recognition.
- R6: `busy` stays high for exactly `PROG_CYCLES` cycles after a program and `ERASE_CYCLES` cycles after an erase. Bus cycles presented while busy have no effect.
- R7: A cycle that does not match the expected triplet returns the sequencer to idle. That same cycle is re-checked as a possible first triplet, so an unknown closing byte fires nothing.
- R8: A cycle with `cyc_nop` high is ignored in every state and does not break a sequence in progress.
- R9: A read returns `{~d[7], d[6:0]}` of the programmed byte while a program runs, and the byte d once it ends. `poll_valid` and `poll_data` appear one cycle after `rd_en`.
- R10: A read returns 00 while an erase runs and FF after it ends.
- R11: In verify mode a read returns `{6'b0, boot_mode, lockout_enabled}`, giving 00 to 03.
- R12: With lockout enabled and `boot_mode` high, a program or erase request fires `op_code` 7, does not raise `busy` and leaves the polling state unchanged, unless `hv_override` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Bus cycle strobe |
| cyc_nop | input | 1 | Marks the strobed cycle as a no-operation (precharge) |
| cyc_row | input | ROW_W | Row field of the bus cycle |
| cyc_col | input | COL_W | Column field of the bus cycle |
| cyc_data | input | DATA_W | Data word of the bus cycle |
| boot_mode | input | 1 | Boot area is the active target |
| hv_override | input | 1 | Bypasses the lockout refusal while high |
| rd_en | input | 1 | Status read request |
| op_valid | output | 1 | One-cycle pulse for a decoded operation |
| op_code | output | 3 | Decoded operation code |
| op_sector | output | SECT_W | Sector index of the operation |
| busy | output | 1 | Program or erase running |
| poll_valid | output | 1 | Read data valid |
| poll_data | output | 8 | Polling or lockout status byte |

## Verification
A decoded operation appears on `op_valid` one cycle after its closing bus cycle, and `busy` rises on that same edge. The bench therefore drives each bus cycle at a falling edge and checks the result at the next falling edge. A read answers one cycle after `rd_en`, so the expected byte is queued when the request is driven and compared when `poll_valid` is seen. Busy length is measured by counting the falling edges on which `busy` is high, starting at the one right after the launching cycle. Any `op_valid` with no queued expectation counts as a miscompare, which covers the cycles that must be ignored.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_ARM,
        ST_EXT1,
        ST_EXT2,
        ST_ERS_ARM,
        ST_PROG_BUSY,
        ST_ERASE_BUSY
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROGRAM    = 3'd1,
        OP_ERASE      = 3'd2,
        OP_CONT_TEST  = 3'd3,
        OP_LOCK       = 3'd4,
        OP_VERIFY_ON  = 3'd5,
        OP_VERIFY_OFF = 3'd6,
        OP_REFUSED    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LAST_NONE,
        LAST_PROG,
        LAST_ERASE
    } last_e;

    localparam logic [7:0] KEY_AA   = 8'hAA;
    localparam logic [7:0] KEY_55   = 8'h55;
    localparam logic [7:0] KEY_2A   = 8'h2A;
    localparam logic [7:0] KEY_PGM  = 8'hA0;
    localparam logic [7:0] KEY_EXT  = 8'h80;
    localparam logic [7:0] KEY_ERS  = 8'h30;
    localparam logic [7:0] KEY_CONT = 8'h70;
    localparam logic [7:0] KEY_LOCK = 8'h40;
    localparam logic [7:0] KEY_VON  = 8'h90;
    localparam logic [7:0] KEY_VOFF = 8'hF0;

endpackage

// File: rtl/ucs_op_timer.sv
module ucs_op_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);

    assert_count_down_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_zero_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_zero) |=> cnt_zero);

endmodule

// File: rtl/ucs_seq_fsm.sv
module ucs_seq_fsm
    import ucs_pkg::*;
#(
    parameter int ROW_W        = 13,
    parameter int COL_W        = 8,
    parameter int SECT_W       = 3,
    parameter int CNT_W        = 6,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_nop,
    input  logic [ROW_W-1:0]  cyc_row,
    input  logic [COL_W-1:0]  cyc_col,
    input  logic [7:0]        cyc_byte,
    input  logic              boot_mode,
    input  logic              lock_en,
    input  logic              hv_override,
    input  logic              tmr_zero,
    output logic              busy,
    output logic              fire,
    output op_e               fire_code,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              op_valid,
    output op_e               op_code,
    output logic [SECT_W-1:0] op_sector
);

    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES - 1);

    seq_state_e state_q, state_d;

    logic take, rc_aa55, rc_552a, m_first, m_second, guard;
    logic [SECT_W-1:0] sector_d;

    assign take     = cyc_valid && !cyc_nop;
    assign rc_aa55  = (cyc_row == ROW_W'(KEY_AA)) && (cyc_col == COL_W'(KEY_55));
    assign rc_552a  = (cyc_row == ROW_W'(KEY_55)) && (cyc_col == COL_W'(KEY_2A));
    assign m_first  = rc_aa55 && (cyc_byte == KEY_AA);
    assign m_second = rc_552a && (cyc_byte == KEY_55);
    assign guard    = boot_mode && lock_en && !hv_override;
    assign sector_d = cyc_row[ROW_W-1 -: SECT_W];
    assign busy     = (state_q == ST_PROG_BUSY) || (state_q == ST_ERASE_BUSY);

    seq_state_e restart;
    assign restart = m_first ? ST_UNLK1 : ST_IDLE;

    always_comb begin
        state_d   = state_q;
        fire      = 1'b0;
        fire_code = OP_NONE;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take && m_first) state_d = ST_UNLK1;
            end
            ST_UNLK1: begin
                if (take) state_d = m_second ? ST_UNLK2 : restart;
            end
            ST_UNLK2: begin
                if (take) begin
                    if (rc_aa55 && cyc_byte == KEY_PGM)      state_d = ST_PGM_ARM;
                    else if (rc_aa55 && cyc_byte == KEY_EXT) state_d = ST_EXT1;
                    else                                     state_d = restart;
                end
            end
            ST_PGM_ARM: begin
                if (take) begin
                    fire = 1'b1;
                    if (guard) begin
                        fire_code = OP_REFUSED;
                        state_d   = ST_IDLE;
                    end else begin
                        fire_code = OP_PROGRAM;
                        state_d   = ST_PROG_BUSY;
                        tmr_load  = 1'b1;
                        tmr_val   = PROG_LD;
                    end
                end
            end
            ST_EXT1: begin
                if (take) state_d = m_first ? ST_EXT2 : restart;
            end
            ST_EXT2: begin
                if (take) begin
                    if (m_second) begin
                        state_d = ST_ERS_ARM;
                    end else if (rc_aa55 && (cyc_byte == KEY_CONT || cyc_byte == KEY_LOCK ||
                                             cyc_byte == KEY_VON  || cyc_byte == KEY_VOFF)) begin
                        fire    = 1'b1;
                        state_d = ST_IDLE;
                        if (cyc_byte == KEY_CONT)      fire_code = OP_CONT_TEST;
                        else if (cyc_byte == KEY_LOCK) fire_code = OP_LOCK;
                        else if (cyc_byte == KEY_VON)  fire_code = OP_VERIFY_ON;
                        else                           fire_code = OP_VERIFY_OFF;
                    end else begin
                        state_d = restart;
                    end
                end
            end
            ST_ERS_ARM: begin
                if (take) begin
                    if (cyc_byte == KEY_ERS) begin
                        fire = 1'b1;
                        if (guard) begin
                            fire_code = OP_REFUSED;
                            state_d   = ST_IDLE;
                        end else begin
                            fire_code = OP_ERASE;
                            state_d   = ST_ERASE_BUSY;
                            tmr_load  = 1'b1;
                            tmr_val   = ERASE_LD;
                        end
                    end else begin
                        state_d = restart;
                    end
                end
            end
            ST_PROG_BUSY, ST_ERASE_BUSY: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid  <= 1'b0;
            op_code   <= OP_NONE;
            op_sector <= '0;
        end else begin
            op_valid <= fire;
            if (fire) begin
                op_code   <= fire_code;
                op_sector <= sector_d;
            end
        end
    end

    assert_ignore_busy_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !op_valid);

    assert_nop_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_nop && !busy) |=> $stable(state_q));

    assert_launch_busy_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_PROGRAM || op_code == OP_ERASE)) |-> busy);

    assert_refuse_idle_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_REFUSED) |-> !busy);

    assert_single_pulse_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

endmodule

// File: rtl/ucs_status.sv
module ucs_status
    import ucs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  op_e        fire_code,
    input  logic [7:0] cyc_byte,
    input  logic       busy,
    input  logic       boot_mode,
    input  logic       rd_en,
    output logic       lock_en,
    output logic       poll_valid,
    output logic [7:0] poll_data
);

    logic       verify_q;
    last_e      last_q;
    logic [7:0] ld_q;
    logic [7:0] status_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_en  <= 1'b0;
            verify_q <= 1'b0;
            last_q   <= LAST_NONE;
            ld_q     <= 8'h00;
        end else if (fire) begin
            unique case (fire_code)
                OP_LOCK:       lock_en  <= 1'b1;
                OP_VERIFY_ON:  verify_q <= 1'b1;
                OP_VERIFY_OFF: verify_q <= 1'b0;
                OP_PROGRAM: begin
                    last_q <= LAST_PROG;
                    ld_q   <= cyc_byte;
                end
                OP_ERASE:      last_q   <= LAST_ERASE;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (verify_q) begin
            status_byte = {6'b0, boot_mode, lock_en};
        end else begin
            unique case (last_q)
                LAST_PROG:  status_byte = busy ? {~ld_q[7], ld_q[6:0]} : ld_q;
                LAST_ERASE: status_byte = busy ? 8'h00 : 8'hFF;
                default:    status_byte = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_valid <= 1'b0;
            poll_data  <= 8'h00;
        end else begin
            poll_valid <= rd_en;
            if (rd_en) poll_data <= status_byte;
        end
    end

    assert_verify_format_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && verify_q) |=> (poll_data[7:2] == 6'b0));

    assert_erase_poll_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && !verify_q && last_q == LAST_ERASE) |=> (poll_data == 8'h00));

    assert_lock_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        lock_en |=> lock_en);

endmodule

// File: rtl/unlock_cmd_seq.sv
module unlock_cmd_seq
    import ucs_pkg::*;
#(
    parameter int ROW_W        = 13,
    parameter int COL_W        = 8,
    parameter int DATA_W       = 32,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic              cyc_nop,
    input  logic [ROW_W-1:0]  cyc_row,
    input  logic [COL_W-1:0]  cyc_col,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              boot_mode,
    input  logic              hv_override,
    input  logic              rd_en,
    output logic              op_valid,
    output logic [2:0]        op_code,
    output logic [SECT_W-1:0] op_sector,
    output logic              busy,
    output logic              poll_valid,
    output logic [7:0]        poll_data
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [7:0]       cyc_byte;
    logic             unused_hi;
    logic             fire, tmr_load, tmr_zero, lock_en;
    logic [CNT_W-1:0] tmr_val;
    op_e              fire_code, op_code_e;

    assign cyc_byte  = cyc_data[7:0];
    assign unused_hi = ^cyc_data[DATA_W-1:8];
    assign op_code   = op_code_e;

    ucs_seq_fsm #(
        .ROW_W(ROW_W), .COL_W(COL_W), .SECT_W(SECT_W), .CNT_W(CNT_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cyc_valid(cyc_valid), .cyc_nop(cyc_nop),
        .cyc_row(cyc_row), .cyc_col(cyc_col), .cyc_byte(cyc_byte),
        .boot_mode(boot_mode), .lock_en(lock_en), .hv_override(hv_override),
        .tmr_zero(tmr_zero), .busy(busy),
        .fire(fire), .fire_code(fire_code),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .op_valid(op_valid), .op_code(op_code_e), .op_sector(op_sector)
    );

    ucs_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .cnt_zero(tmr_zero)
    );

    ucs_status u_status (
        .clk(clk), .rst_n(rst_n),
        .fire(fire), .fire_code(fire_code), .cyc_byte(cyc_byte),
        .busy(busy), .boot_mode(boot_mode), .rd_en(rd_en),
        .lock_en(lock_en), .poll_valid(poll_valid), .poll_data(poll_data)
    );

endmodule

// File: tb/unlock_cmd_seq_tb.sv
module unlock_cmd_seq_tb;

    localparam int P = 20;
    localparam int E = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0, cyc_nop = 1'b0;
    logic [12:0] cyc_row = '0;
    logic [7:0]  cyc_col = '0;
    logic [31:0] cyc_data = '0;
    logic        boot_mode = 1'b0, hv_override = 1'b0, rd_en = 1'b0;
    logic        op_valid, busy, poll_valid;
    logic [2:0]  op_code, op_sector;
    logic [7:0]  poll_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [5:0] op_q[$];
    string      op_tag_q[$];
    logic [7:0] poll_q[$];
    string      poll_tag_q[$];

    always #5 clk = ~clk;

    unlock_cmd_seq #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cyc_valid(cyc_valid), .cyc_nop(cyc_nop),
        .cyc_row(cyc_row), .cyc_col(cyc_col), .cyc_data(cyc_data),
        .boot_mode(boot_mode), .hv_override(hv_override), .rd_en(rd_en),
        .op_valid(op_valid), .op_code(op_code), .op_sector(op_sector),
        .busy(busy), .poll_valid(poll_valid), .poll_data(poll_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic [12:0] r, input logic [7:0] c, input logic [31:0] d, input logic nop);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_nop = nop; cyc_row = r; cyc_col = c; cyc_data = d;
        @(negedge clk);
        cyc_valid = 1'b0; cyc_nop = 1'b0;
    endtask

    task automatic unlock2();
        bus(13'h0AA, 8'h55, 32'hF0F0_F0AA, 1'b0);
        bus(13'h055, 8'h2A, 32'h1234_5655, 1'b0);
    endtask

    task automatic ext_prefix();
        unlock2();
        bus(13'h0AA, 8'h55, 32'h0000_0080, 1'b0);
        bus(13'h0AA, 8'h55, 32'hFFFF_FFAA, 1'b0);
    endtask

    task automatic program_cmd(input logic [12:0] r, input logic [31:0] d);
        unlock2();
        bus(13'h0AA, 8'h55, 32'h0000_00A0, 1'b0);
        bus(r, 8'h07, d, 1'b0);
    endtask

    task automatic erase_cmd(input logic [12:0] r);
        ext_prefix();
        bus(13'h055, 8'h2A, 32'h0000_0055, 1'b0);
        bus(r, 8'h00, 32'hABCD_0030, 1'b0);
    endtask

    task automatic five_cmd(input logic [7:0] key);
        ext_prefix();
        bus(13'h0AA, 8'h55, {24'h0, key}, 1'b0);
    endtask

    task automatic expect_op(input logic [2:0] code, input logic [2:0] sec, input string tag);
        op_q.push_back({code, sec});
        op_tag_q.push_back(tag);
    endtask

    task automatic read_poll(input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        poll_q.push_back(exp);
        poll_tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic busy_len(input int exp, input string tag);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (op_valid) begin
                if (op_q.size() == 0) begin
                    chk(1'b0, "R6/R7/R8 unexpected op", {op_code, op_sector}, 0);
                end else begin
                    logic [5:0] e;
                    string t;
                    e = op_q.pop_front();
                    t = op_tag_q.pop_front();
                    chk({op_code, op_sector} == e, t, {op_code, op_sector}, e);
                end
            end
            if (poll_valid) begin
                if (poll_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected poll", poll_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = poll_q.pop_front();
                    t = poll_tag_q.pop_front();
                    chk(poll_data == e, t, poll_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(op_valid == 1'b0, "R1 op_valid after reset", op_valid, 0);
        chk(poll_valid == 1'b0, "R1 poll_valid after reset", poll_valid, 0);
        read_poll(8'hFF, "R1 initial poll");

        // R2 / R5 program, upper data junk; R6 busy length; R9 final value
        expect_op(3'd1, 3'd3, "R2 program op");
        program_cmd(13'h0C12, 32'hDEAD_BE37);
        busy_len(P, "R6 program busy length");
        read_poll(8'h37, "R9 program done");

        // R9 polling during program
        expect_op(3'd1, 3'd7, "R2 program op second");
        program_cmd(13'h1FFF, 32'h0000_00C3);
        read_poll(8'h43, "R9 program busy poll");
        wait_idle();
        read_poll(8'hC3, "R9 program done second");

        // R3 erase, R6 length, R10 final
        expect_op(3'd2, 3'd2, "R3 erase op");
        erase_cmd(13'h0800);
        busy_len(E, "R6 erase busy length");
        read_poll(8'hFF, "R10 erase done");

        // R10 busy poll, R6 commands ignored while busy
        expect_op(3'd2, 3'd7, "R3 erase op sector 7");
        erase_cmd(13'h1C05);
        read_poll(8'h00, "R10 erase busy poll");
        five_cmd(8'h40);
        wait_idle();
        read_poll(8'hFF, "R10 erase done second");

        // R4 verify on, R11 status shows lock still off (R6)
        expect_op(3'd5, 3'd0, "R4 verify on");
        five_cmd(8'h90);
        read_poll(8'h00, "R11 R6 lock unaffected while busy");

        expect_op(3'd4, 3'd0, "R4 lock enable");
        five_cmd(8'h40);
        read_poll(8'h01, "R11 lock bit");
        boot_mode = 1'b1;
        read_poll(8'h03, "R11 boot and lock bits");

        expect_op(3'd6, 3'd0, "R4 verify off");
        five_cmd(8'hF0);
        read_poll(8'hFF, "R4 verify exit poll");

        expect_op(3'd3, 3'd0, "R4 continuity test");
        five_cmd(8'h70);

        // R12 refusal
        expect_op(3'd7, 3'd1, "R12 program refused");
        program_cmd(13'h0400, 32'h0000_0011);
        chk(busy == 1'b0, "R12 no busy on refusal", busy, 0);
        read_poll(8'hFF, "R12 poll unchanged");
        expect_op(3'd7, 3'd5, "R12 erase refused");
        erase_cmd(13'h1400);
        chk(busy == 1'b0, "R12 no busy on erase refusal", busy, 0);

        hv_override = 1'b1;
        expect_op(3'd1, 3'd1, "R12 override program");
        program_cmd(13'h0400, 32'h0000_0011);
        chk(busy == 1'b1, "R12 override busy", busy, 1);
        wait_idle();
        hv_override = 1'b0;
        boot_mode = 1'b0;

        // R7 mismatch re-checked as first cycle
        expect_op(3'd3, 3'd0, "R7 restart via mismatch");
        bus(13'h0AA, 8'h55, 32'h0000_00AA, 1'b0);
        bus(13'h055, 8'h2A, 32'h0000_0055, 1'b0);
        bus(13'h0AA, 8'h55, 32'h0000_00AA, 1'b0);
        bus(13'h055, 8'h2A, 32'h0000_0055, 1'b0);
        bus(13'h0AA, 8'h55, 32'h0000_0080, 1'b0);
        bus(13'h0AA, 8'h55, 32'h0000_00AA, 1'b0);
        bus(13'h0AA, 8'h55, 32'h0000_0070, 1'b0);
        // R7 unknown closing byte and wrong sixth byte fire nothing
        five_cmd(8'h11);
        ext_prefix();
        bus(13'h055, 8'h2A, 32'h0000_0055, 1'b0);
        bus(13'h0800, 8'h00, 32'h0000_0031, 1'b0);
        bus(13'h055, 8'h2A, 32'h0000_0055, 1'b0);
        chk(busy == 1'b0, "R7 no launch after mismatch", busy, 0);
        read_poll(8'h11, "R7 poll unchanged");

        // R8 no-operation cycles inside a sequence
        expect_op(3'd1, 3'd6, "R8 program with nop cycles");
        unlock2();
        bus(13'h1234, 8'h99, 32'h0000_0077, 1'b1);
        bus(13'h0AA, 8'h55, 32'h0000_00A0, 1'b0);
        bus(13'h0000, 8'h00, 32'h0000_0000, 1'b1);
        bus(13'h1800, 8'h01, 32'h0000_0005, 1'b0);
        read_poll(8'h85, "R9 R8 program busy poll");
        wait_idle();
        read_poll(8'h05, "R8 program data");

        repeat (3) @(negedge clk);
        chk(op_q.size() == 0, "R7 all expected ops seen", op_q.size(), 0);
        chk(poll_q.size() == 0, "R9 all reads answered", poll_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule